// File: doc/BRIEF.md
# Descriptor Ownership Command Queue

This block is the register-mapped front end of a packet-processing engine's command queue. A host writes one descriptor through a plain 32-bit register port. The descriptor has three words: a control word whose two low bits carry an ownership status, a packet source address and a result destination address. The block decides when that descriptor is ready to run, claims one of two processing contexts for it, and tracks who owns it until the engine reports that it has finished.

There are two trigger modes. Ring mode requires the engine-enable bit to be set and a non-zero ring size. In ring mode the host hands the descriptor over by writing the status field to "engine owns". Otherwise the block is in direct mode. There, the ownership bits do not trigger anything, and the write to the destination address, the last word of the queue, starts the command. In either mode the status field reads back "engine owns" once a context has been claimed, and "host owns" once the engine reports done for that context.

The engine side is a valid/ready launch stream. `launch_valid` rises when a command is pending and a context is free. Once raised, `launch_valid`, `launch_ctx` and the presented addresses hold until `launch_ready` is seen high at a clock edge. The engine may hold `launch_ready` low for as long as it likes. Holding it low stalls the command and delays the claim, but it never drops the command. The addresses presented are the current register contents. The host should not rewrite them while a command is pending. Completion comes back as a one-cycle `done_valid` pulse with the context index.

Top module: `desc_cmd_queue`

## Requirements
- R1: After reset, all four registers read 0 and `launch_valid` is 0. The registers are the control word at 0x0, the source address at 0x4, the destination address at 0x8 and the configuration word at 0xC.
- R2: The source (0x4) and destination (0x8) registers store and read back any 32-bit value, including byte-unaligned addresses.
- R3: Direct mode applies when configuration bit 0 (engine enable) is 0, or when it is 1 and the ring size in configuration bits 15:8 is 0. In direct mode a write to 0x8 triggers a command, and a write of status 01 to the control word does not.
- R4: In ring mode (bit 0 = 1 and ring size > 0), a control-word write that changes status bits 1:0 from any value other than 01 to 01 triggers a command. Writes of 00 or 11, and writes to 0x8, do not trigger.
- R5: While `launch_valid` is high and `launch_ready` is low, `launch_valid` and `launch_ctx` hold. The context offered is always a free one, picked lowest index first.
- R6: On a launch handshake, status bits 1:0 of the control word become 01 (engine owns) in the next cycle. Control bits 31:2 keep their host-written value.
- R7: A `done_valid` pulse whose `done_ctx` matches the context of the current command sets the status to 10 (host owns) in the next cycle. A done pulse for any other context frees that context and leaves the status unchanged.
- R8: When both contexts are busy, a trigger is held pending with `launch_valid` low. It is launched on the first context that becomes free.
- R9: A trigger that arrives while a command is already pending is dropped. It sets a sticky overflow flag, read at configuration bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host byte offset for read and write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| launch_valid | output | 1 | A command is offered to the engine |
| launch_ready | input | 1 | The engine accepts the offered command |
| launch_ctx | output | 1 | Context index claimed by the offered command |
| launch_src | output | 32 | Packet source address |
| launch_dst | output | 32 | Result destination address |
| done_valid | input | 1 | The engine finished the command in `done_ctx` |
| done_ctx | input | 1 | Context index of the finished command |

## Verification
On every cycle, the checker confirms four things. The launch offer holds still under back-pressure. It only ever names a free context, and it is absent when both contexts are busy. The overflow flag never clears. It also checks the cycle-exact status moves to 01 after a handshake and to 10 after a matching done. Only the bench's scenarios can show the rest. These are the mode-dependent trigger decisions (direct versus ring, and the ignored 00, 11 and destination writes), the lowest-index context choice, and the pending command that launches after a release. They also include the dropped trigger and the unchanged status after a done for a foreign context. A scoreboard compares each launched context and address pair against what the stimulus predicts.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int DATA_W = 32;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_SRC  = 4'h4;
  localparam logic [3:0] OFF_DST  = 4'h8;
  localparam logic [3:0] OFF_CFG  = 4'hC;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_RING_LSB = 8;
  localparam int CFG_OVF_BIT  = 16;

  typedef enum logic [1:0] {
    OWN_NONE   = 2'b00,
    OWN_ENGINE = 2'b01,
    OWN_HOST   = 2'b10,
    OWN_RSVD   = 2'b11
  } own_e;
endpackage

// File: rtl/cq_regs.sv
module cq_regs
  import cq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RING_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              claim,
  input  logic              finish,
  input  logic              overflow,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] src_addr,
  output logic [DATA_W-1:0] dst_addr,
  output own_e              status,
  output logic              trigger
);
  localparam int HI_W = DATA_W - 2;

  logic [HI_W-1:0]   ctrl_hi_q;
  own_e              status_q;
  logic [DATA_W-1:0] src_q, dst_q;
  logic              en_q;
  logic [RING_W-1:0] ring_q;
  logic              ring_mode;
  logic              wr_ctrl, wr_src, wr_dst, wr_cfg;
  logic [DATA_W-1:0] cfg_word;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(OFF_CTRL));
  assign wr_src  = wr_en && (addr == ADDR_W'(OFF_SRC));
  assign wr_dst  = wr_en && (addr == ADDR_W'(OFF_DST));
  assign wr_cfg  = wr_en && (addr == ADDR_W'(OFF_CFG));

  assign ring_mode = en_q && (ring_q != '0);

  always_comb begin
    trigger = 1'b0;
    if (ring_mode)
      trigger = wr_ctrl && (wdata[1:0] == OWN_ENGINE) && (status_q != OWN_ENGINE);
    else
      trigger = wr_dst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_hi_q <= '0;
      status_q  <= OWN_NONE;
      src_q     <= '0;
      dst_q     <= '0;
      en_q      <= 1'b0;
      ring_q    <= '0;
    end else begin
      if (wr_ctrl) ctrl_hi_q <= wdata[DATA_W-1:2];
      if (claim)
        status_q <= OWN_ENGINE;
      else if (finish)
        status_q <= OWN_HOST;
      else if (wr_ctrl)
        status_q <= own_e'(wdata[1:0]);
      if (wr_src) src_q <= wdata;
      if (wr_dst) dst_q <= wdata;
      if (wr_cfg) begin
        en_q   <= wdata[CFG_EN_BIT];
        ring_q <= wdata[CFG_RING_LSB +: RING_W];
      end
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_EN_BIT]              = en_q;
    cfg_word[CFG_RING_LSB +: RING_W]  = ring_q;
    cfg_word[CFG_OVF_BIT]             = overflow;
  end

  always_comb begin
    unique case (addr)
      ADDR_W'(OFF_CTRL): rdata = {ctrl_hi_q, status_q};
      ADDR_W'(OFF_SRC):  rdata = src_q;
      ADDR_W'(OFF_DST):  rdata = dst_q;
      ADDR_W'(OFF_CFG):  rdata = cfg_word;
      default:           rdata = '0;
    endcase
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign status   = status_q;
endmodule

// File: rtl/cq_ctx_alloc.sv
module cq_ctx_alloc #(
  parameter int NUM_CTX = 2,
  parameter int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic [CTX_W-1:0]   alloc_idx,
  input  logic               release_valid,
  input  logic [CTX_W-1:0]   release_idx,
  output logic [NUM_CTX-1:0] busy,
  output logic               any_free,
  output logic [CTX_W-1:0]   free_idx
);
  logic [NUM_CTX-1:0] busy_q;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        busy_q[g] <= 1'b0;
      else if (alloc && alloc_idx == CTX_W'(g))
        busy_q[g] <= 1'b1;
      else if (release_valid && release_idx == CTX_W'(g))
        busy_q[g] <= 1'b0;
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--)
      if (!busy_q[i]) free_idx = CTX_W'(i);
  end

  assign any_free = ~&busy_q;
  assign busy     = busy_q;
endmodule

// File: rtl/cq_sched.sv
module cq_sched #(
  parameter int CTX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger,
  input  logic             any_free,
  input  logic [CTX_W-1:0] free_idx,
  input  logic             launch_ready,
  input  logic             done_valid,
  input  logic [CTX_W-1:0] done_ctx,
  output logic             launch_valid,
  output logic [CTX_W-1:0] launch_ctx,
  output logic             fire,
  output logic             finish,
  output logic             overflow,
  output logic [CTX_W-1:0] owner_ctx,
  output logic             owner_act
);
  logic             pending_q, ovf_q, hold_q, own_act_q;
  logic [CTX_W-1:0] hold_ctx_q, own_ctx_q;

  assign launch_valid = pending_q && (hold_q || any_free);
  assign launch_ctx   = hold_q ? hold_ctx_q : free_idx;
  assign fire         = launch_valid && launch_ready;
  assign finish       = done_valid && own_act_q && (done_ctx == own_ctx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      ovf_q      <= 1'b0;
      hold_q     <= 1'b0;
      hold_ctx_q <= '0;
      own_act_q  <= 1'b0;
      own_ctx_q  <= '0;
    end else begin
      if (fire)
        pending_q <= trigger;
      else if (trigger && !pending_q)
        pending_q <= 1'b1;
      if (trigger && pending_q && !fire)
        ovf_q <= 1'b1;
      hold_q <= launch_valid && !launch_ready;
      if (launch_valid && !launch_ready)
        hold_ctx_q <= launch_ctx;
      if (fire) begin
        own_act_q <= 1'b1;
        own_ctx_q <= launch_ctx;
      end else if (finish) begin
        own_act_q <= 1'b0;
      end
    end
  end

  assign overflow  = ovf_q;
  assign owner_ctx = own_ctx_q;
  assign owner_act = own_act_q;
endmodule

// File: rtl/desc_cmd_queue.sv
module desc_cmd_queue
  import cq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int RING_W  = 8,
  parameter int NUM_CTX = 2,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              launch_valid,
  input  logic              launch_ready,
  output logic [CTX_W-1:0]  launch_ctx,
  output logic [31:0]       launch_src,
  output logic [31:0]       launch_dst,
  input  logic              done_valid,
  input  logic [CTX_W-1:0]  done_ctx
);
  logic               trigger, fire, finish, overflow, any_free, owner_act;
  logic [CTX_W-1:0]   free_idx, owner_ctx;
  logic [NUM_CTX-1:0] ctx_busy;
  own_e               status;

  cq_regs #(.ADDR_W(ADDR_W), .RING_W(RING_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
    .wdata(host_wdata), .claim(fire), .finish(finish), .overflow(overflow),
    .rdata(host_rdata), .src_addr(launch_src), .dst_addr(launch_dst),
    .status(status), .trigger(trigger)
  );

  cq_ctx_alloc #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .alloc(fire), .alloc_idx(launch_ctx),
    .release_valid(done_valid), .release_idx(done_ctx),
    .busy(ctx_busy), .any_free(any_free), .free_idx(free_idx)
  );

  cq_sched #(.CTX_W(CTX_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .any_free(any_free),
    .free_idx(free_idx), .launch_ready(launch_ready), .done_valid(done_valid),
    .done_ctx(done_ctx), .launch_valid(launch_valid), .launch_ctx(launch_ctx),
    .fire(fire), .finish(finish), .overflow(overflow),
    .owner_ctx(owner_ctx), .owner_act(owner_act)
  );
endmodule

// File: rtl/desc_cmd_queue_checker.sv
module desc_cmd_queue_checker #(
  parameter int NUM_CTX = 2,
  parameter int CTX_W   = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               launch_valid,
  input logic               launch_ready,
  input logic [CTX_W-1:0]   launch_ctx,
  input logic               done_valid,
  input logic [CTX_W-1:0]   done_ctx,
  input logic [1:0]         status,
  input logic [CTX_W-1:0]   owner_ctx,
  input logic               owner_act,
  input logic [NUM_CTX-1:0] ctx_busy,
  input logic               overflow
);
  AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid && !launch_ready |=> launch_valid && $stable(launch_ctx)); // R5
  AST_OFFER_FREE_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> !ctx_busy[launch_ctx]); // R5
  AST_CLAIM_SETS_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid && launch_ready |=> status == 2'b01); // R6
  AST_DONE_SETS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && owner_act && done_ctx == owner_ctx && !(launch_valid && launch_ready)
    |=> status == 2'b10); // R7
  AST_NO_OFFER_ALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    &ctx_busy |-> !launch_valid); // R8
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
endmodule

bind desc_cmd_queue desc_cmd_queue_checker #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_ready(launch_ready),
  .launch_ctx(launch_ctx), .done_valid(done_valid), .done_ctx(done_ctx),
  .status(status), .owner_ctx(owner_ctx), .owner_act(owner_act),
  .ctx_busy(ctx_busy), .overflow(overflow)
);

// File: tb/desc_cmd_queue_test.sv
module desc_cmd_queue_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        host_wr_en = 0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        launch_valid;
  logic        launch_ready = 1;
  logic [0:0]  launch_ctx;
  logic [31:0] launch_src, launch_dst;
  logic        done_valid = 0;
  logic [0:0]  done_ctx = '0;

  int checks = 0;
  int errors = 0;
  logic [64:0] exp_q[$];
  logic [31:0] v;
  localparam logic [31:0] SRC = 32'h1234_5677;

  always #5 clk = ~clk;

  desc_cmd_queue uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done(input logic c);
    @(negedge clk);
    done_valid = 1; done_ctx = c;
    @(negedge clk);
    done_valid = 0;
  endtask

  task automatic expect_launch(input logic c, input logic [31:0] d);
    exp_q.push_back({c, SRC, d});
  endtask

  // monitor: pops the scoreboard on every handshake (R5)
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && launch_valid && launch_ready) begin
      if (exp_q.size() == 0)
        check(0, "R3/R4 unexpected launch", {31'b0, launch_ctx, launch_dst}, 64'h0);
      else begin
        logic [64:0] e;
        e = exp_q.pop_front();
        check({launch_ctx, launch_src, launch_dst} == e, "R5 launch item",
              {launch_src, launch_dst}, e[63:0]);
        check(launch_ctx == e[64], "R5 launch ctx", 64'(launch_ctx), 64'(e[64]));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd(4'h0, v); check(v == 0, "R1 ctrl", 64'(v), 0);
    rd(4'h4, v); check(v == 0, "R1 src", 64'(v), 0);
    rd(4'h8, v); check(v == 0, "R1 dst", 64'(v), 0);
    rd(4'hC, v); check(v == 0, "R1 cfg", 64'(v), 0);
    check(launch_valid == 0, "R1 launch_valid", 64'(launch_valid), 0);

    // R2 unaligned addresses, R3 direct trigger on dst write
    wr(4'h4, SRC);
    rd(4'h4, v); check(v == SRC, "R2 src readback", 64'(v), 64'(SRC));
    expect_launch(0, 32'h89AB_CDEF);
    wr(4'h8, 32'h89AB_CDEF);
    idle(1);
    rd(4'h0, v); check(v[1:0] == 2'b01, "R6 status engine owns", 64'(v[1:0]), 1);
    rd(4'h8, v); check(v == 32'h89AB_CDEF, "R2 dst readback", 64'(v), 64'h89AB_CDEF);
    done(0);
    rd(4'h0, v); check(v[1:0] == 2'b10, "R7 status host owns", 64'(v[1:0]), 2);

    // R3 status write 01 in direct mode does not trigger
    wr(4'h0, 32'h1);
    idle(3);
    check(launch_valid == 0, "R3 no trigger from status", 64'(launch_valid), 0);
    wr(4'h0, 32'h0);

    // R5 back-pressure holds the offer
    @(negedge clk) launch_ready = 0;
    expect_launch(0, 32'h3);
    wr(4'h8, 32'h3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      check(launch_valid == 1 && launch_ctx == 0, "R5 offer held", {launch_valid, launch_ctx}, 2'b10);
    end
    @(negedge clk) launch_ready = 1;
    idle(2);
    // R5 lowest free index: ctx0 busy, so ctx1
    expect_launch(1, 32'h4);
    wr(4'h8, 32'h4);
    idle(2);
    check(exp_q.size() == 0, "R5 ctx1 launched", 64'(exp_q.size()), 0);

    // R8 both busy: pending, no offer
    wr(4'h8, 32'h5);
    idle(2);
    check(launch_valid == 0, "R8 held while busy", 64'(launch_valid), 0);
    // R9 second trigger while pending
    wr(4'h8, 32'h5);
    rd(4'hC, v); check(v[16] == 1, "R9 overflow flag", 64'(v[16]), 1);
    expect_launch(0, 32'h5);
    done(0);
    idle(2);
    check(exp_q.size() == 0, "R8 launched after release", 64'(exp_q.size()), 0);
    rd(4'h0, v); check(v[1:0] == 2'b01, "R6 status after pending launch", 64'(v[1:0]), 1);
    done(1);
    rd(4'h0, v); check(v[1:0] == 2'b01, "R7 foreign done keeps status", 64'(v[1:0]), 1);
    done(0);
    rd(4'h0, v); check(v[1:0] == 2'b10, "R7 owner done", 64'(v[1:0]), 2);

    // R4 ring mode
    wr(4'hC, 32'h0000_0801);
    wr(4'h8, 32'h6);
    idle(3);
    check(launch_valid == 0, "R4 dst write ignored", 64'(launch_valid), 0);
    wr(4'h0, 32'h3);
    idle(3);
    check(launch_valid == 0, "R4 status 11 ignored", 64'(launch_valid), 0);
    wr(4'h0, 32'h0);
    idle(3);
    check(launch_valid == 0, "R4 status 00 ignored", 64'(launch_valid), 0);
    expect_launch(0, 32'h6);
    wr(4'h0, 32'h1);
    idle(2);
    check(exp_q.size() == 0, "R4 handover launched", 64'(exp_q.size()), 0);
    done(0);
    rd(4'h0, v); check(v[1:0] == 2'b10, "R7 ring done", 64'(v[1:0]), 2);
    expect_launch(0, 32'h6);
    wr(4'h0, 32'hABCD_0001);
    idle(2);
    check(exp_q.size() == 0, "R4 relaunch from 10", 64'(exp_q.size()), 0);
    rd(4'h0, v); check(v == 32'hABCD_0001, "R6 upper control bits kept", 64'(v), 64'hABCD_0001);
    done(0);

    // R3 enable set with ring size 0 is direct
    wr(4'hC, 32'h1);
    expect_launch(0, 32'h7);
    wr(4'h8, 32'h7);
    idle(2);
    check(exp_q.size() == 0, "R3 zero ring size direct", 64'(exp_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule